// File: doc/BRIEF.md
# Sector Transfer Sequencer

This block moves one sector of data through the single data register of an 8-bit disk interface. Firmware starts a transfer in one of four mutually exclusive ways, chosen by the direction input and the DMA enable sampled at start: programmed read, programmed write, DMA read and DMA write. Each accepted host access moves one byte between the data register and an external sector buffer port. The buffer is addressed by a byte counter that runs from 0 to the sector size minus one.

Once the last data byte has moved, the block signals the firmware and waits for a completion status byte. It then presents that byte on the data register for one ordinary programmed read. If the interrupt enable is set when the status byte is loaded, the interrupt line is raised at that point and held until the host reads the byte. A command that returns only a status byte loads it straight from idle. A light reset from the register interface abandons any transfer. No data register access is accepted while the firmware reports busy.

Top module: `stx_sequencer`

## Requirements
- R1: After rst_n is released, drq, irq, xfer_done and buf_we are 0 and buf_addr is 0.
- R2: In a programmed write (xfer_rd=0, dma_en=0 at start), each io_wr with data_sel=1, dack=0 and fw_busy=0 drives buf_we=1 in the same cycle, with buf_wdata=host_wdata and buf_addr equal to the byte index (0 upward). After the byte with index SECTOR_BYTES-1, xfer_done is 1 from the next cycle.
- R3: In a programmed read (xfer_rd=1, dma_en=0), host_rdata equals buf_rdata while buf_addr holds the byte index. Each io_rd with data_sel=1, dack=0 and fw_busy=0 advances buf_addr by one.
- R4: In a DMA transfer (dma_en=1 at start), drq rises the second cycle after start. Bytes are accepted only by a strobe with dack=1 while drq=1. drq is 0 in the cycle after each accepted byte and returns to 1 the cycle after that. It stays 0 once SECTOR_BYTES bytes have moved. Strobes with dack=0 during the DMA data phase are ignored.
- R5: In a programmed transfer, strobes with dack=1 are ignored: buf_addr does not advance and buf_we stays 0.
- R6: While fw_busy=1, no strobe is accepted (buf_addr unchanged, buf_we=0), and drq is 0 in the following cycle.
- R7: A stat_load pulse while xfer_done=1 captures stat_byte. From the next cycle host_rdata shows it. One io_rd with data_sel=1, dack=0, fw_busy=0 consumes it and returns the block to idle (xfer_done=0, a new start is accepted).
- R8: irq becomes 1 in the cycle after stat_load if irq_en was 1 at that load, and stays 0 if irq_en was 0. It returns to 0 in the cycle after the status read.
- R9: A stat_load pulse while idle (no transfer started) goes straight to the status state, with the same irq and read behaviour as R7 and R8.
- R10: A light_rst pulse returns the block to idle. In the next cycle drq=0, irq=0, xfer_done=0 and buf_addr=0.
- R11: xfer_start is ignored unless the block is idle: the running mode, direction and byte index are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| light_rst | input | 1 | Pulse: abandon the transfer and return to idle |
| xfer_start | input | 1 | Pulse: begin a sector transfer |
| xfer_rd | input | 1 | Direction at start: 1 = drive to host, 0 = host to drive |
| dma_en | input | 1 | DMA enable from the control register, sampled at start |
| irq_en | input | 1 | Interrupt enable, sampled at status load |
| fw_busy | input | 1 | Firmware busy: blocks all data register accesses |
| stat_load | input | 1 | Pulse: load the completion status byte |
| stat_byte | input | 8 | Completion status value |
| xfer_done | output | 1 | All sector bytes moved, waiting for status |
| io_rd | input | 1 | Host read strobe (one cycle per access) |
| io_wr | input | 1 | Host write strobe (one cycle per access) |
| data_sel | input | 1 | Decoded select of the data register |
| dack | input | 1 | DMA acknowledge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Data register read value |
| drq | output | 1 | DMA request |
| irq | output | 1 | Completion interrupt |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_we | output | 1 | Sector buffer write enable |
| buf_wdata | output | 8 | Sector buffer write data |
| buf_rdata | input | 8 | Sector buffer read data (combinational) |

## Verification
The assertions take host strobes to be single-cycle pulses already synchronised to clk, and light_rst, xfer_start and stat_load to be single-cycle pulses. They also take a DMA strobe to carry dack only while the block requests. The bench drives every control input at the falling edge and holds a strobe for exactly one rising edge. It waits for drq before issuing a DMA acknowledge, except in deliberate probes that check an ignored access. Random gaps, blocked accesses during busy and wrong-type strobes are mixed into the random byte streams.

// File: rtl/stx_pkg.sv
// Package: shared state encoding for the sector transfer sequencer.
// Assumes nothing beyond 1800-2017 enum support.
package stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no transfer, waiting for start or status
        ST_DATA = 2'd1,   // sector bytes moving
        ST_WAIT = 2'd2,   // all bytes moved, waiting for status byte
        ST_STAT = 2'd3    // status byte offered on the data register
    } stx_state_t;
endpackage

// File: rtl/stx_counter.sv
// Byte index counter. Clears on clr, advances on inc, and flags the last index.
// Assumes clr and inc are never needed together with inc winning.
module stx_counter #(
    parameter int SECTOR_BYTES = 512,
    localparam int AW = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] cnt,
    output logic          last
);
    localparam logic [AW-1:0] LAST_IDX = AW'(SECTOR_BYTES - 1);

    // Counter register: reset and clear take priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    // Last-index decode.
    always_comb last = (cnt == LAST_IDX);
endmodule

// File: rtl/stx_drq.sv
// DMA request generator. Requests while in the DMA data phase, drops for one
// cycle after each accepted byte, and is held low while busy or on light reset.
// Assumes dma_phase is already registered state.
module stx_drq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dma_phase,
    input  logic take,
    input  logic busy,
    output logic drq
);
    // Request register: re-arms one cycle after each taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n) drq <= 1'b0;
        else        drq <= !clr && dma_phase && !take && !busy;
    end
endmodule

// File: rtl/stx_ctrl.sv
// Transfer control FSM. Qualifies host strobes against the current mode,
// sequences data, wait and status phases, holds the status byte and irq.
// Assumes strobes are single-cycle pulses synchronous to clk.
module stx_ctrl
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              light_rst,
    input  logic              xfer_start,
    input  logic              xfer_rd,
    input  logic              dma_en,
    input  logic              irq_en,
    input  logic              fw_busy,
    input  logic              stat_load,
    input  logic [DATA_W-1:0] stat_byte,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              data_sel,
    input  logic              dack,
    input  logic              drq,
    input  logic              cnt_last,
    output stx_state_t        st,
    output logic              take,
    output logic              cnt_clr,
    output logic              dir_rd_q,
    output logic              dma_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              irq
);
    logic strobe_ok;
    logic take_stat;
    logic load_ok;

    // Strobe qualification: direction, DMA/PIO match and busy gate.
    always_comb begin
        strobe_ok = data_sel && !fw_busy && (dir_rd_q ? io_rd : io_wr);
        take      = (st == ST_DATA) && strobe_ok && (dma_q ? (dack && drq) : !dack);
        take_stat = (st == ST_STAT) && data_sel && !fw_busy && io_rd && !dack;
        load_ok   = stat_load && ((st == ST_WAIT) || (st == ST_IDLE && !xfer_start));
        cnt_clr   = light_rst || (st == ST_IDLE && xfer_start);
    end

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || light_rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (xfer_start)            st <= ST_DATA;
                         else if (stat_load)        st <= ST_STAT;
                ST_DATA: if (take && cnt_last)      st <= ST_WAIT;
                ST_WAIT: if (stat_load)             st <= ST_STAT;
                ST_STAT: if (take_stat)             st <= ST_IDLE;
                default:                            st <= ST_IDLE;
            endcase
        end
    end

    // Mode latch: direction and DMA choice held for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd_q <= 1'b0;
            dma_q    <= 1'b0;
        end else if (st == ST_IDLE && xfer_start && !light_rst) begin
            dir_rd_q <= xfer_rd;
            dma_q    <= dma_en;
        end
    end

    // Status byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   stat_q <= '0;
        else if (load_ok && !light_rst) stat_q <= stat_byte;
    end

    // Completion interrupt: set on status load if enabled, cleared on status read.
    always_ff @(posedge clk) begin
        if (!rst_n || light_rst)  irq <= 1'b0;
        else if (load_ok)         irq <= irq_en;
        else if (take_stat)       irq <= 1'b0;
    end
endmodule

// File: rtl/stx_sequencer.sv
// Top of the sector transfer sequencer. Connects the control FSM, the byte
// counter and the DMA request generator to the host, firmware and buffer ports.
// Assumes the sector buffer returns read data combinationally from buf_addr.
module stx_sequencer
    import stx_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 8,
    localparam int AW          = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              light_rst,
    input  logic              xfer_start,
    input  logic              xfer_rd,
    input  logic              dma_en,
    input  logic              irq_en,
    input  logic              fw_busy,
    input  logic              stat_load,
    input  logic [DATA_W-1:0] stat_byte,
    output logic              xfer_done,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              data_sel,
    input  logic              dack,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              drq,
    output logic              irq,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic [DATA_W-1:0] buf_rdata
);
    stx_state_t        st;
    logic              take;
    logic              cnt_clr;
    logic              dir_rd_q;
    logic              dma_q;
    logic [DATA_W-1:0] stat_q;
    logic [AW-1:0]     cnt;
    logic              cnt_last;
    logic              dma_phase;

    stx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .light_rst(light_rst),
        .xfer_start(xfer_start), .xfer_rd(xfer_rd), .dma_en(dma_en),
        .irq_en(irq_en), .fw_busy(fw_busy), .stat_load(stat_load),
        .stat_byte(stat_byte), .io_rd(io_rd), .io_wr(io_wr),
        .data_sel(data_sel), .dack(dack), .drq(drq), .cnt_last(cnt_last),
        .st(st), .take(take), .cnt_clr(cnt_clr), .dir_rd_q(dir_rd_q),
        .dma_q(dma_q), .stat_q(stat_q), .irq(irq)
    );

    stx_counter #(.SECTOR_BYTES(SECTOR_BYTES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(take),
        .cnt(cnt), .last(cnt_last)
    );

    stx_drq u_drq (
        .clk(clk), .rst_n(rst_n), .clr(light_rst), .dma_phase(dma_phase),
        .take(take), .busy(fw_busy), .drq(drq)
    );

    // Output steering: buffer port, read mux and completion flag.
    always_comb begin
        dma_phase  = (st == ST_DATA) && dma_q;
        buf_addr   = cnt;
        buf_we     = take && !dir_rd_q;
        buf_wdata  = host_wdata;
        host_rdata = (st == ST_STAT) ? stat_q : buf_rdata;
        xfer_done  = (st == ST_WAIT);
    end
endmodule

// File: rtl/stx_sequencer_chk.sv
// Checker for stx_sequencer: temporal properties over ports and internal state.
// Assumes strobes and control pulses last one cycle.
module stx_sequencer_chk
    import stx_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int AW = $clog2(SECTOR_BYTES)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       light_rst,
    input logic       xfer_start,
    input logic       fw_busy,
    input logic       drq,
    input logic       irq,
    input logic       buf_we,
    input logic       xfer_done,
    input logic       take,
    input logic       dma_q,
    input logic       dir_rd_q,
    input stx_state_t st,
    input logic [AW-1:0] cnt
);
    localparam logic [AW-1:0] LAST_IDX = AW'(SECTOR_BYTES - 1);

    AST_DRQ_IN_DMA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (st == ST_DATA && dma_q)); // R4
    AST_DRQ_DROPS_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dma_q) |=> !drq); // R4
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fw_busy |-> !buf_we); // R6
    AST_BUSY_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        fw_busy |=> !drq); // R6
    AST_IRQ_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st == ST_STAT)); // R8
    AST_LIGHT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        light_rst |=> (st == ST_IDLE && !drq && !irq && cnt == '0)); // R10
    AST_WE_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (st == ST_DATA && !dir_rd_q)); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cnt == LAST_IDX && !light_rst) |=> xfer_done); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && xfer_start && !take && !light_rst) |=> $stable(cnt)); // R11
endmodule

bind stx_sequencer stx_sequencer_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .light_rst(light_rst), .xfer_start(xfer_start),
    .fw_busy(fw_busy), .drq(drq), .irq(irq), .buf_we(buf_we),
    .xfer_done(xfer_done), .take(take), .dma_q(dma_q), .dir_rd_q(dir_rd_q),
    .st(st), .cnt(cnt)
);

// File: tb/stx_sequencer_test.sv
// Bench for stx_sequencer: random byte streams with directed corner cases.
module stx_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       light_rst = 0, xfer_start = 0, xfer_rd = 0, dma_en = 0, irq_en = 0;
    logic       fw_busy = 0, stat_load = 0;
    logic [7:0] stat_byte = 0;
    logic       xfer_done;
    logic       io_rd = 0, io_wr = 0, data_sel = 0, dack = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       drq, irq;
    logic [8:0] buf_addr;
    logic       buf_we;
    logic [7:0] buf_wdata;
    logic [7:0] buf_rdata;

    logic [7:0] rd_img [N];
    logic [7:0] wr_img [N];
    logic [7:0] exp_img [N];
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stx_sequencer uut (
        .clk(clk), .rst_n(rst_n), .light_rst(light_rst), .xfer_start(xfer_start),
        .xfer_rd(xfer_rd), .dma_en(dma_en), .irq_en(irq_en), .fw_busy(fw_busy),
        .stat_load(stat_load), .stat_byte(stat_byte), .xfer_done(xfer_done),
        .io_rd(io_rd), .io_wr(io_wr), .data_sel(data_sel), .dack(dack),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .drq(drq), .irq(irq),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // Sector buffer model: separate read image and captured writes.
    assign buf_rdata = rd_img[buf_addr];
    always @(posedge clk) if (buf_we) wr_img[buf_addr] <= buf_wdata;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rand_byte();
        return 8'($urandom);
    endfunction

    task automatic clear_strobes();
        io_rd = 0; io_wr = 0; data_sel = 0; dack = 0; fw_busy = 0;
    endtask

    task automatic start(input logic rd, input logic dma);
        @(negedge clk); xfer_rd = rd; dma_en = dma; xfer_start = 1;
        @(negedge clk); xfer_start = 0;
    endtask

    // Probe that a strobe is ignored: buf_addr stays and buf_we stays low.
    task automatic ignored(input string req, input logic rd, input logic dk,
                           input logic busy, input int idx);
        @(negedge clk); io_rd = rd; io_wr = !rd; data_sel = 1; dack = dk; fw_busy = busy;
        #1 chk(req, buf_we, 0);
        @(negedge clk); clear_strobes();
        chk(req, buf_addr, idx);
    endtask

    // One programmed data byte (R2 write / R3 read).
    task automatic pio_byte(input logic rd, input int idx, input logic [7:0] wv);
        @(negedge clk); io_rd = rd; io_wr = !rd; data_sel = 1; host_wdata = wv;
        #1;
        if (rd) chk("R3 read data", host_rdata, rd_img[idx]);
        else begin
            chk("R2 write enable", buf_we, 1);
            chk("R2 write addr", buf_addr, idx);
        end
        @(negedge clk); clear_strobes();
    endtask

    // One DMA byte: wait for drq, strobe with dack, check drop (R4).
    task automatic dma_byte(input logic rd, input int idx, input logic [7:0] wv);
        int w = 0;
        while (!drq && w < 8) begin @(negedge clk); w++; end
        chk("R4 drq before byte", drq, 1);
        io_rd = rd; io_wr = !rd; data_sel = 1; dack = 1; host_wdata = wv;
        #1;
        if (rd) chk("R4 dma read data", host_rdata, rd_img[idx]);
        else    chk("R4 dma write addr", buf_addr, idx);
        @(negedge clk);
        chk("R4 drq drop", drq, 0);
        clear_strobes();
    endtask

    // Load status and read it back (R7, R8).
    task automatic status_phase(input logic ien, input string req);
        logic [7:0] s = rand_byte();
        @(negedge clk); stat_byte = s; irq_en = ien; stat_load = 1;
        @(negedge clk); stat_load = 0;
        chk({req, " R8 irq set"}, irq, ien);
        chk({req, " R7 status shown"}, host_rdata, s);
        ignored({req, " R7 dack read ignored"}, 1, 1, 0, 0);
        chk({req, " R7 status held"}, host_rdata, s);
        io_rd = 1; data_sel = 1;
        #1 chk({req, " R7 status read"}, host_rdata, s);
        @(negedge clk); clear_strobes();
        chk({req, " R8 irq cleared"}, irq, 0);
        chk({req, " R7 idle"}, xfer_done, 0);
    endtask

    initial begin
        void'($urandom(32'd20211121));
        for (int i = 0; i < N; i++) begin rd_img[i] = rand_byte(); wr_img[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 drq", drq, 0); chk("R1 irq", irq, 0);
        chk("R1 done", xfer_done, 0); chk("R1 we", buf_we, 0);
        chk("R1 addr", buf_addr, 0);

        // Programmed write with random gaps, busy and dack probes.
        start(0, 0);
        for (int i = 0; i < N; i++) begin
            exp_img[i] = rand_byte();
            if ($urandom % 16 == 0) ignored("R6 busy write", 0, 0, 1, i);
            if ($urandom % 16 == 0) ignored("R5 dack in pio write", 0, 1, 0, i);
            if ($urandom % 4 == 0) @(negedge clk);
            pio_byte(0, i, exp_img[i]);
        end
        chk("R2 done after last", xfer_done, 1);
        for (int i = 0; i < N; i++) chk("R2 sector content", wr_img[i], exp_img[i]);
        status_phase(0, "pio write");

        // Programmed read, including an ignored restart (R11).
        start(1, 0);
        for (int i = 0; i < N; i++) begin
            if (i == 7) begin
                @(negedge clk); xfer_start = 1; xfer_rd = 0; dma_en = 1;
                @(negedge clk); xfer_start = 0;
                chk("R11 index kept", buf_addr, 7);
                ignored("R11 write ignored in read", 0, 0, 0, 7);
                chk("R11 no drq", drq, 0);
            end
            if ($urandom % 16 == 0) ignored("R6 busy read", 1, 0, 1, i);
            pio_byte(1, i, 0);
        end
        chk("R3 done", xfer_done, 1);
        status_phase(1, "pio read");

        // DMA read with interrupt.
        start(1, 1);
        @(negedge clk);
        chk("R4 drq rises", drq, 1);
        for (int i = 0; i < N; i++) begin
            if ($urandom % 16 == 0) ignored("R4 non-dack read ignored", 1, 0, 0, i);
            if (i == 20) begin
                @(negedge clk); fw_busy = 1;
                @(negedge clk); chk("R6 busy holds drq low", drq, 0);
                fw_busy = 0;
            end
            dma_byte(1, i, 0);
        end
        repeat (3) begin @(negedge clk); chk("R4 drq stays low", drq, 0); end
        chk("R4 done", xfer_done, 1);
        status_phase(1, "dma read");

        // DMA write, interrupt disabled: completion by polling.
        start(0, 1);
        for (int i = 0; i < N; i++) begin
            exp_img[i] = rand_byte();
            dma_byte(0, i, exp_img[i]);
        end
        chk("R4 dma write done", xfer_done, 1);
        for (int i = 0; i < N; i++) chk("R4 dma sector content", wr_img[i], exp_img[i]);
        status_phase(0, "dma write");

        // Status-only command from idle.
        status_phase(1, "R9 one-byte");

        // Light reset mid DMA.
        start(1, 1);
        for (int i = 0; i < 5; i++) dma_byte(1, i, 0);
        @(negedge clk); light_rst = 1;
        @(negedge clk); light_rst = 0;
        chk("R10 drq", drq, 0); chk("R10 irq", irq, 0);
        chk("R10 addr", buf_addr, 0); chk("R10 done", xfer_done, 0);
        @(negedge clk); chk("R10 drq stays low", drq, 0);
        start(1, 0);
        pio_byte(1, 0, 0);
        chk("R10 restart index", buf_addr, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule